// File: doc/BRIEF.md
# Triangle-Wave Frequency Dither Generator

This block produces a signed offset code that is added to a master oscillator's frequency control word, so that the oscillator sweeps in a triangle above and below its center value. The triangle is equally tall on both sides of zero, so the average frequency stays at center for every amplitude setting. It runs on the master clock. The modulation period is one of three master-clock divisions (2048, 4096 or 8192 clocks), picked by a 2-bit rate select. A 2-bit amplitude select picks a peak deviation of 1%, 2%, 4% or 8% of center. A spread-enable input gates the whole function.

The core is a three-state machine that moves a signed level counter. In IDLE the level is held at zero. The machine leaves IDLE for UP when the enable condition becomes true. It goes from UP to DOWN when the level reaches the positive peak, and from DOWN to UP when the level reaches the negative peak. From UP or DOWN it returns to IDLE as soon as the enable condition drops. The level counter always has the same full scale. The step size per clock grows as the period shortens, so that a quarter period always spans center to peak. The amplitude select then shifts the level left by 0 to 3 bits. The offset word treats 1% of center as 2048 units. Rate and amplitude are sampled only when the level is at zero, so every half-swing is completed with the settings it began with.

Top module: `tri_dither_gen`

## Requirements
- R1: After reset, and while reset is held, `offset_o` is 0 and `dither_active` is 0.
- R2: Dither is active only when `spread_en` is 1 and `rate_sel` is not 00. With `rate_sel` = 00, or with `spread_en` = 0, `offset_o` stays 0 and `dither_active` stays 0.
- R3: Enable is sampled at a clock edge E. From edge E on, `dither_active` is 1 and the offset rises from zero. The offset reaches the positive peak exactly N/4 edges after E. N is 2048 for rate 01, 4096 for rate 10 and 8192 for rate 11.
- R4: After the positive peak, the offset falls in a straight line to the negative peak over N/2 edges. It then rises back to zero over N/4 edges, so one full triangle takes N edges. After that the pattern repeats.
- R5: The positive and negative peaks are equal in size: 2048 shifted left by `amp_sel` (00 gives 2048 for 1%, 01 gives 4096, 10 gives 8192, 11 gives 16384). The offset never goes beyond them.
- R6: Once the enable condition is seen false at an edge, that same edge sets `offset_o` to exactly 0 and clears `dither_active`. A later enable starts again from zero and rises.
- R7: A change of `rate_sel` or `amp_sel` while dithering has no effect until the level next reaches zero. The new values set the first step away from zero and every step after it.
- R8: While active, the offset moves by exactly (2^(3-rate)) << amp each clock, up or down. Here rate and amp are the settings currently in effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spread_en | input | 1 | Spread enable; 1 allows dithering |
| rate_sel | input | 2 | Modulation period select: 00 off, 01 N=2048, 10 N=4096, 11 N=8192 |
| amp_sel | input | 2 | Peak deviation select: 00 1%, 01 2%, 10 4%, 11 8% |
| offset_o | output | 16 | Signed two's-complement offset for the frequency control word |
| dither_active | output | 1 | High while the triangle is running |

## Verification
Two functions can act on the same cycle: loading new rate and amplitude at the midpoint, and stepping the level away from zero. On that edge the step must already use the new settings. To provoke this, the bench changes the rate and amplitude part-way through a rising half-swing. It then checks three things against a triangle model built from the requirements: the old slope holds until the level reaches zero, the first sample after zero has the new step and the new shift, and the next peak has the new size at the new quarter period. The bench also drops the enable in the middle of a swing, to check that the immediate return to zero wins over the stepping.

// File: rtl/tri_dither_pkg.sv
package tri_dither_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_UP   = 2'b01,
        S_DOWN = 2'b10
    } tri_state_t;

    // Level step per clock for a rate code: the step grows as the period
    // shrinks, so a quarter period always covers center to full scale.
    function automatic logic [3:0] step_of(input logic [1:0] code);
        logic [3:0] s;
        unique case (code)
            2'b01:   s = 4'd4;
            2'b10:   s = 4'd2;
            2'b11:   s = 4'd1;
            default: s = 4'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tri_dither_cfg.sv
module tri_dither_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic [1:0] rate_in,
    input  logic [1:0] amp_in,
    output logic [1:0] rate_cur,
    output logic [1:0] amp_cur
);

    // Settings are adopted only on the midpoint strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_cur <= 2'b00;
            amp_cur  <= 2'b00;
        end else if (take) begin
            rate_cur <= rate_in;
            amp_cur  <= amp_in;
        end
    end

endmodule

// File: rtl/tri_dither_fsm.sv
module tri_dither_fsm
    import tri_dither_pkg::*;
#(
    parameter int PEAK_LOG2 = 11,
    localparam int LVL_W = PEAK_LOG2 + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [1:0]              rate_new,
    input  logic [1:0]              rate_cur,
    output tri_state_t              state_q,
    output logic signed [LVL_W-1:0] level_q,
    output logic                    take
);

    localparam logic signed [LVL_W-1:0] PEAK_P = LVL_W'(1) <<< PEAK_LOG2;
    localparam logic signed [LVL_W-1:0] PEAK_N = -PEAK_P;

    tri_state_t              state_d;
    logic signed [LVL_W-1:0] level_d;
    logic signed [LVL_W-1:0] step_s;
    logic signed [LVL_W-1:0] step_cur;
    logic signed [LVL_W-1:0] sum_up;
    logic signed [LVL_W-1:0] sum_dn;

    // Midpoint strobe: settings are reloaded whenever the level sits at zero.
    assign take     = en && (level_q == '0);
    assign step_s   = $signed({{(LVL_W-4){1'b0}}, step_of(take ? rate_new : rate_cur)});
    assign step_cur = $signed({{(LVL_W-4){1'b0}}, step_of(rate_cur)});
    assign sum_up   = level_q + step_s;
    assign sum_dn   = level_q - step_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            level_q <= '0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
        end
    end

    always_comb begin
        state_d = state_q;
        level_d = level_q;
        unique case (state_q)
            S_IDLE: begin
                level_d = '0;
                if (en) begin
                    state_d = S_UP;
                    level_d = sum_up;
                end
            end
            S_UP: begin
                if (!en) begin
                    state_d = S_IDLE;
                    level_d = '0;
                end else begin
                    level_d = sum_up;
                    if (sum_up == PEAK_P) state_d = S_DOWN;
                end
            end
            S_DOWN: begin
                if (!en) begin
                    state_d = S_IDLE;
                    level_d = '0;
                end else begin
                    level_d = sum_dn;
                    if (sum_dn == PEAK_N) state_d = S_UP;
                end
            end
            default: begin
                state_d = S_IDLE;
                level_d = '0;
            end
        endcase
    end

    // R5: level never exceeds full scale in either direction
    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q <= PEAK_P) && (level_q >= PEAK_N));

    // R8: each active cycle moves the level by exactly one step of the settings in force
    p_slope_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |->
            (((level_q - $past(level_q)) == step_cur) ||
             (($past(level_q) - level_q) == step_cur)));

    // R6: the idle state always holds the level at center
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (level_q == '0));

endmodule

// File: rtl/tri_dither_scale.sv
module tri_dither_scale #(
    parameter int LVL_W = 13,
    localparam int OFF_W = LVL_W + 3
) (
    input  logic signed [LVL_W-1:0] level,
    input  logic [1:0]              amp,
    output logic signed [OFF_W-1:0] offset
);

    logic signed [OFF_W-1:0] ext;
    logic signed [OFF_W-1:0] shifted [4];

    assign ext = {{(OFF_W-LVL_W){level[LVL_W-1]}}, level};

    for (genvar g = 0; g < 4; g++) begin : g_shift
        assign shifted[g] = ext <<< g;
    end

    assign offset = shifted[amp];

endmodule

// File: rtl/tri_dither_gen.sv
module tri_dither_gen
    import tri_dither_pkg::*;
#(
    parameter int PEAK_LOG2 = 11,
    localparam int LVL_W = PEAK_LOG2 + 2,
    localparam int OFF_W = LVL_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spread_en,
    input  logic [1:0]              rate_sel,
    input  logic [1:0]              amp_sel,
    output logic signed [OFF_W-1:0] offset_o,
    output logic                    dither_active
);

    logic                    en;
    logic                    take;
    logic [1:0]              rate_cur;
    logic [1:0]              amp_cur;
    tri_state_t              state_q;
    logic signed [LVL_W-1:0] level_q;

    assign en = spread_en && (rate_sel != 2'b00);

    tri_dither_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .rate_in  (rate_sel),
        .amp_in   (amp_sel),
        .rate_cur (rate_cur),
        .amp_cur  (amp_cur)
    );

    tri_dither_fsm #(.PEAK_LOG2(PEAK_LOG2)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .rate_new (rate_sel),
        .rate_cur (rate_cur),
        .state_q  (state_q),
        .level_q  (level_q),
        .take     (take)
    );

    tri_dither_scale #(.LVL_W(LVL_W)) u_scale (
        .level  (level_q),
        .amp    (amp_cur),
        .offset (offset_o)
    );

    assign dither_active = (state_q != S_IDLE);

    // R2: a false enable condition leaves the block inactive after the edge
    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!spread_en || rate_sel == 2'b00) |=> !dither_active);

    // R6: an inactive block presents a zero offset
    p_zero_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dither_active |-> (offset_o == '0));

    // R7: settings in force stay put away from the midpoint
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && $past(state_q) != S_IDLE && $past(level_q) != '0)
            |-> ($stable(rate_cur) && $stable(amp_cur)));

endmodule

// File: tb/tri_dither_gen_bench.sv
module tri_dither_gen_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               spread_en = 1'b0;
    logic [1:0]         rate_sel = 2'b00;
    logic [1:0]         amp_sel = 2'b00;
    logic signed [15:0] offset_o;
    logic               dither_active;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    tri_dither_gen u_tri_dither_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .spread_en     (spread_en),
        .rate_sel      (rate_sel),
        .amp_sel       (amp_sel),
        .offset_o      (offset_o),
        .dither_active (dither_active)
    );

    // Triangle model from the requirements: k edges after enable.
    function automatic int model(input int rate, input int amp, input int k);
        int q, step, pos, kk;
        q    = 1 << (rate + 8);
        step = 1 << (3 - rate);
        kk   = k % (4 * q);
        if (kk <= q)          pos = kk;
        else if (kk <= 3 * q) pos = 2 * q - kk;
        else                  pos = kk - 4 * q;
        return (pos * step) <<< amp;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_all();
        spread_en = 1'b0;
        rate_sel  = 2'b00;
        edges(2);
    endtask

    task automatic t_reset();
        edges(3);
        check("R1 offset in reset", int'(offset_o), 0);
        check("R1 active in reset", int'(dither_active), 0);
        rst_n = 1'b1;
        edges(2);
        check("R1 offset after reset", int'(offset_o), 0);
    endtask

    task automatic t_gate();
        spread_en = 1'b1; rate_sel = 2'b00; amp_sel = 2'b11;
        edges(50);
        check("R2 rate 00 offset", int'(offset_o), 0);
        check("R2 rate 00 active", int'(dither_active), 0);
        spread_en = 1'b0; rate_sel = 2'b01;
        edges(50);
        check("R2 spread off offset", int'(offset_o), 0);
        check("R2 spread off active", int'(dither_active), 0);
        idle_all();
    endtask

    task automatic t_period(input int rate, input int amp);
        int n, bad, first_k, first_a, first_e, prev, slope_bad, maxv, minv;
        n = 1 << (rate + 10);
        bad = 0; slope_bad = 0; prev = 0; maxv = 0; minv = 0;
        first_k = 0; first_a = 0; first_e = 0;
        rate_sel = 2'(rate); amp_sel = 2'(amp); spread_en = 1'b1;
        for (int k = 1; k <= n + 3; k++) begin
            int a, e, d;
            edges(1);
            a = int'(offset_o);
            e = model(rate, amp, k);
            if (a != e && bad == 0) begin first_k = k; first_a = a; first_e = e; end
            if (a != e) bad++;
            d = a - prev;
            if (d != ((1 << (3 - rate)) <<< amp) && -d != ((1 << (3 - rate)) <<< amp))
                slope_bad++;
            prev = a;
            if (a > maxv) maxv = a;
            if (a < minv) minv = a;
            if (k == 1) check("R3 active after enable edge", int'(dither_active), 1);
            if (k == n / 4) check("R3 positive peak at N/4", a, 2048 <<< amp);
            if (k == 3 * n / 4) check("R4 negative peak at 3N/4", a, -(2048 <<< amp));
            if (k == n) check("R4 zero at full period", a, 0);
        end
        if (bad != 0)
            $display("FAIL R4 waveform: first mismatch at edge %0d actual=%0d expected=%0d",
                     first_k, first_a, first_e);
        checks++; if (bad != 0) errors++;
        check("R8 slope mismatches", slope_bad, 0);
        check("R5 maximum", maxv, 2048 <<< amp);
        check("R5 minimum", minv, -(2048 <<< amp));
        idle_all();
    endtask

    task automatic t_disable();
        rate_sel = 2'b01; amp_sel = 2'b01; spread_en = 1'b1;
        edges(300);
        check("R3 mid ramp", int'(offset_o), model(1, 1, 300));
        spread_en = 1'b0;
        edges(1);
        check("R6 offset zero after drop", int'(offset_o), 0);
        check("R6 inactive after drop", int'(dither_active), 0);
        spread_en = 1'b1;
        edges(1);
        check("R6 restart from center", int'(offset_o), 8);
        edges(599);
        rate_sel = 2'b00;
        edges(1);
        check("R6 rate 00 clears offset", int'(offset_o), 0);
        check("R2 rate 00 clears active", int'(dither_active), 0);
        idle_all();
    endtask

    task automatic t_midpoint();
        rate_sel = 2'b01; amp_sel = 2'b00; spread_en = 1'b1;
        edges(100);
        rate_sel = 2'b11; amp_sel = 2'b11;
        edges(412);
        check("R7 old peak kept", int'(offset_o), 2048);
        edges(188);
        check("R7 old slope kept", int'(offset_o), (1024 - 700) * 4);
        edges(324);
        check("R7 zero reached", int'(offset_o), 0);
        edges(1);
        check("R7 first new step", int'(offset_o), -8);
        edges(2047);
        check("R7 new negative peak", int'(offset_o), -16384);
        idle_all();
    endtask

    task automatic t_reset_mid();
        rate_sel = 2'b10; amp_sel = 2'b10; spread_en = 1'b1;
        edges(200);
        rst_n = 1'b0;
        edges(1);
        check("R1 reset while active offset", int'(offset_o), 0);
        check("R1 reset while active flag", int'(dither_active), 0);
        rst_n = 1'b1;
        idle_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_gate();
        t_period(1, 0);
        t_period(2, 3);
        t_period(3, 1);
        t_disable();
        t_midpoint();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule